// File: doc/BRIEF.md
# Synchronous BCD Decade Counter

This block is one decimal digit of a synchronous counter. A 4-bit BCD value with weights 8, 4, 2 and 1 sits in four D flip-flops that share a single clock edge. Each clock with the count enable high moves the value one step through 0 to 9 and back to 0. A carry output marks the terminal count, so a system can divide a clock by ten or sequence ten events.

The next value is not chosen by comparing against nine. Fixed toggle equations per bit produce it: bit 1 always toggles, bit 2 toggles on Q1·¬Q8, bit 4 toggles on Q1·Q2, and bit 8 toggles on Q1·Q8 + Q1·Q2·Q4. The carry is Q1·Q8. The same equations therefore set where the six non-BCD codes go. Each even code steps to the next odd code. Each odd code drops back into the legal range. An upset in the state is cleared within two enabled clocks, without a dedicated check.

A synchronous active-low reset clears the digit. A load port lets a test place any 4-bit code, including the illegal ones, into the state.

Top module: `bcd_decade_counter`

## Requirements
- R1: With `rst_n` low at a rising clock edge, `digit` becomes 0000 and `carry` is low after that edge. This applies whatever `load_en` and `cnt_en` are doing.
- R2: With `rst_n` high and `load_en` high at a rising edge, `digit` takes `load_val` (any of the 16 codes) after that edge, whatever `cnt_en` is.
- R3: With `rst_n` high, `load_en` low and `cnt_en` low at a rising edge, `digit` keeps its value, including when it holds an illegal code.
- R4: With the count enabled and `digit` in 0..9, the next value is `digit`+1, and 9 (1001) is followed by 0 (0000).
- R5: Within the legal range, `carry` is high exactly when `digit` is 9 and low for 0 through 8.
- R6: For illegal codes, `carry` is high for 11 (1011), 13 (1101) and 15 (1111) and low for 10 (1010), 12 (1100) and 14 (1110).
- R7: With the count enabled, code 10 steps to 11, 12 to 13 and 14 to 15.
- R8: With the count enabled, code 11 steps to 6 (0110), 13 to 4 (0100) and 15 to 2 (0010).
- R9: Starting from any illegal code, `digit` is back in 0..9 after at most two enabled clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; every state bit updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low, highest priority |
| cnt_en | input | 1 | Advance the digit by one step when high |
| load_en | input | 1 | Test preload strobe; places `load_val` into the state |
| load_val | input | 4 | Code to preload, BCD weights 8-4-2-1 on bits 3..0 |
| digit | output | 4 | Current state, bit 3 weight 8 down to bit 0 weight 1 |
| carry | output | 1 | Terminal count flag, Q1 AND Q8 of the current state |

## Verification
The main count path is tested with an uninterrupted run of more than ten enabled clocks. This shows the 9-to-0 wrap and the single-cycle carry pulse, and separates them from a plain binary roll past nine. Each of the six illegal codes is preloaded and then stepped twice. This separates the even codes, which must step up by one, from the odd ones, which must fall to 6, 4 or 2; it also confirms the carry value in each. Idle cycles with enable low are placed on both a legal and an illegal code. Reset and load are applied together with the enable to show the order of precedence.

// File: rtl/bcd_pkg.sv
// Package bcd_pkg
// Shared width, type and bit positions for the decade counter.
// Assumes the 8-4-2-1 weighting, with bit 0 as the units bit.
package bcd_pkg;
    localparam int BCD_W   = 4;
    localparam int BIT_Q1  = 0;
    localparam int BIT_Q2  = 1;
    localparam int BIT_Q4  = 2;
    localparam int BIT_Q8  = 3;

    typedef logic [BCD_W-1:0] bcd_t;

    localparam bcd_t BCD_ZERO = '0;
    localparam bcd_t BCD_LAST = bcd_t'(9);
endpackage

// File: rtl/bcd_next_logic.sv
// Module bcd_next_logic
// Works out the next digit from the current one with per-bit toggle
// terms. There is no magnitude compare, so the illegal codes follow
// wherever these equations send them.
// Assumes: a purely combinational path; enable, load and reset are
// applied downstream.
module bcd_next_logic
    import bcd_pkg::*;
(
    input  bcd_t cur,
    output bcd_t nxt
);
    bcd_t tog;

    // Toggle term for each bit
    always_comb begin
        tog[BIT_Q1] = 1'b1;
        tog[BIT_Q2] = cur[BIT_Q1] & ~cur[BIT_Q8];
        tog[BIT_Q4] = cur[BIT_Q1] & cur[BIT_Q2];
        tog[BIT_Q8] = (cur[BIT_Q1] & cur[BIT_Q8])
                    | (cur[BIT_Q1] & cur[BIT_Q2] & cur[BIT_Q4]);
    end

    // Apply the toggles with one XOR per bit
    for (genvar b = 0; b < BCD_W; b++) begin : g_xor
        assign nxt[b] = cur[b] ^ tog[b];
    end
endmodule

// File: rtl/bcd_state_reg.sv
// Module bcd_state_reg
// The four D flip-flops that hold the digit, all on one clock edge.
// Priority order: synchronous active-low reset, then preload, then
// the count step, otherwise hold.
// Assumes: every input is synchronous to clk.
module bcd_state_reg
    import bcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  bcd_t load_val,
    input  logic cnt_en,
    input  bcd_t step_val,
    output bcd_t q
);
    bcd_t d;

    // Pick the D input for each flip-flop
    always_comb begin
        if (!rst_n)       d = BCD_ZERO;
        else if (load_en) d = load_val;
        else if (cnt_en)  d = step_val;
        else              d = q;
    end

    // One flip-flop per bit, all on the shared rising edge
    for (genvar b = 0; b < BCD_W; b++) begin : g_ff
        always_ff @(posedge clk) begin
            q[b] <= d[b];
        end
    end
endmodule

// File: rtl/bcd_carry_decode.sv
// Module bcd_carry_decode
// Terminal-count flag taken straight from the present state.
// Assumes: the carry needs no register; it is also high on the
// illegal codes whose Q1 and Q8 bits are both set.
module bcd_carry_decode
    import bcd_pkg::*;
(
    input  bcd_t cur,
    output logic carry
);
    // Carry is Q1 AND Q8
    always_comb carry = cur[BIT_Q1] & cur[BIT_Q8];
endmodule

// File: rtl/bcd_decade_counter.sv
// Module bcd_decade_counter
// One synchronous BCD digit: the toggle-equation next-state logic,
// the state register and the carry decode.
// Assumes: a single clock domain; load_en is meant for test preloading.
module bcd_decade_counter
    import bcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             load_en,
    input  logic [BCD_W-1:0] load_val,
    output logic [BCD_W-1:0] digit,
    output logic             carry
);
    bcd_t state_q;
    bcd_t state_nxt;

    bcd_next_logic u_next (
        .cur (state_q),
        .nxt (state_nxt)
    );

    bcd_state_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (load_val),
        .cnt_en   (cnt_en),
        .step_val (state_nxt),
        .q        (state_q)
    );

    bcd_carry_decode u_carry (
        .cur   (state_q),
        .carry (carry)
    );

    // Present the state on the output port
    assign digit = state_q;
endmodule

// File: rtl/bcd_decade_checker.sv
// Module bcd_decade_checker
// Port-level properties of the decade counter, attached with bind.
// Assumes: sampled on the rising clock edge of the counter.
module bcd_decade_checker
    import bcd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             load_en,
    input logic [BCD_W-1:0] load_val,
    input logic [BCD_W-1:0] digit,
    input logic             carry
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (digit == BCD_ZERO && !carry)); // R1

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (digit == $past(load_val))); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !cnt_en) |=> $stable(digit)); // R3

    AST_LEGAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && cnt_en && digit <= BCD_LAST) |=>
        (digit == (($past(digit) == BCD_LAST) ? BCD_ZERO : $past(digit) + 4'd1))); // R4

    AST_CARRY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (digit <= BCD_LAST) |-> (carry == (digit == BCD_LAST))); // R5

    AST_CARRY_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (digit > BCD_LAST) |-> (carry == digit[0])); // R6

    AST_EVEN_ILLEGAL_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && cnt_en && digit > BCD_LAST && !digit[0]) |=>
        (digit == $past(digit) + 4'd1)); // R7

    AST_ODD_ILLEGAL_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && cnt_en && digit > BCD_LAST && digit[0]) |=>
        (digit <= BCD_LAST)); // R8
endmodule

bind bcd_decade_counter bcd_decade_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .load_en  (load_en),
    .load_val (load_val),
    .digit    (digit),
    .carry    (carry)
);

// File: tb/tb_bcd_decade_counter.sv
`timescale 1ns/1ps
module tb_bcd_decade_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_val = 4'd0;
    logic [3:0] digit;
    logic       carry;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [3:0] exp_digit;
        logic       exp_carry;
        string      req;
    } item_t;

    item_t sb_q[$];
    logic [3:0] model = 4'd0;

    always #2 clk = ~clk; // 250 MHz

    bcd_decade_counter dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load_en(load_en),
        .load_val(load_val), .digit(digit), .carry(carry)
    );

    // Successor table taken from R4, R7 and R8
    function automatic logic [3:0] succ(input logic [3:0] s);
        case (s)
            4'd9:    return 4'd0;
            4'd10:   return 4'd11;
            4'd11:   return 4'd6;
            4'd12:   return 4'd13;
            4'd13:   return 4'd4;
            4'd14:   return 4'd15;
            4'd15:   return 4'd2;
            default: return s + 4'd1;
        endcase
    endfunction

    // Carry from R5 and R6
    function automatic logic carry_of(input logic [3:0] s);
        return (s == 4'd9) || (s == 4'd11) || (s == 4'd13) || (s == 4'd15);
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic step(input logic r, input logic ld, input logic [3:0] v,
                        input logic en, input string req);
        item_t it;
        @(negedge clk);
        rst_n = r; load_en = ld; load_val = v; cnt_en = en;
        if (!r)      model = 4'd0;
        else if (ld) model = v;
        else if (en) model = succ(model);
        it.exp_digit = model;
        it.exp_carry = carry_of(model);
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare shortly after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (digit !== it.exp_digit || carry !== it.exp_carry) begin
                errors++;
                $display("FAIL %s: digit=%0d carry=%0b expected digit=%0d carry=%0b",
                         it.req, digit, carry, it.exp_digit, it.exp_carry);
            end
        end
    end

    // Explicit R9 check: back in range after two enabled clocks
    task automatic check_recovered(input logic [3:0] from);
        @(negedge clk);
        checks++;
        if (digit > 4'd9) begin
            errors++;
            $display("FAIL R9: from %0d digit=%0d expected <= 9", from, digit);
        end
    endtask

    initial begin
        step(1'b0, 1'b0, 4'd0, 1'b0, "R1 reset");
        step(1'b0, 1'b0, 4'd0, 1'b1, "R1 reset with enable");
        // R4 / R5: a full decade plus a wrap
        for (int i = 0; i < 13; i++) step(1'b1, 1'b0, 4'd0, 1'b1, "R4 R5 count");
        // R3: hold on a legal value
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 4'd0, 1'b0, "R3 hold legal");
        // R1: reset wins over load and enable
        step(1'b0, 1'b1, 4'd7, 1'b1, "R1 priority");
        // R2: load wins over enable
        step(1'b1, 1'b1, 4'd7, 1'b1, "R2 load 7");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 4'd0, 1'b1, "R4 R5 through 9 to 0");
        // R6 / R7 / R8 / R9: each illegal code
        for (int c = 10; c < 16; c++) begin
            step(1'b1, 1'b1, 4'(c), 1'b0, "R2 R6 preload illegal");
            step(1'b1, 1'b0, 4'd0, 1'b1, (c % 2 == 0) ? "R7 even illegal step" : "R8 odd illegal step");
            step(1'b1, 1'b0, 4'd0, 1'b1, "R9 recovery");
            check_recovered(4'(c));
        end
        // R3 / R6: hold on an illegal code
        step(1'b1, 1'b1, 4'd13, 1'b0, "R2 R6 preload 13");
        for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 4'd0, 1'b0, "R3 hold illegal");
        step(1'b1, 1'b0, 4'd0, 1'b1, "R8 13 to 4");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule